// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel. It advances once per cycle in which the counter clock enable is high. It produces one output bit whose waveform depends on a 3-bit operating mode. The host places a count value and a mode on the load inputs and pulses the load strobe. From that moment the channel measures elapsed ticks against the loaded count. The output bit is intended to drive an interrupt request line. The readable count output lets a host interface sample the channel's progress.

Six behaviours are available: a terminal-count flag that stays high, a gate-retriggered one-shot, a rate generator that pulses once per period, a square wave, and two single-tick strobes. The two strobes differ only in whether a gate edge retriggers them. A gate level input is watched for rising edges. In the retriggerable modes such an edge restarts the measurement from the loaded count.

Top module: `pit_channel`

## Requirements
- R1: A load strobe with load value 0 sets the count to 65536. Any load sets the elapsed tick count to zero at that clock edge.
- R2: Mode 0: the output is 0 while the elapsed ticks are fewer than the count. Once the count is reached, the output is 1 and stays 1 until the next load.
- R3: Mode 1: the output is 1 while the elapsed ticks are fewer than the count, and 0 afterwards.
- R4: Mode 2: the output is 1 only when the elapsed ticks are a nonzero multiple of the count. The readable count is the count minus (elapsed ticks modulo count), truncated to 16 bits.
- R5: Mode 3: the output is 1 while (elapsed ticks modulo count) is below (count+1)/2, and 0 otherwise. The readable count is the count minus ((2 x elapsed ticks) modulo count), truncated to 16 bits.
- R6: Modes 4 and 5: the output is 1 exactly when the elapsed ticks equal the count, and 0 at every other time.
- R7: In modes 1, 2, 3 and 5, a 0-to-1 transition of gate between consecutive clock edges sets the elapsed ticks to zero. In modes 0 and 4, gate transitions have no effect on the count or the output.
- R8: In modes 0, 1, 4 and 5 the readable count is (count minus elapsed ticks) modulo 65536, so it wraps past zero to 0xFFFF and continues down.
- R9: After reset the channel is in mode 3 with a count of 65536, and no ticks have elapsed. The output reads 1 and the readable count reads 0.
- R10: Mode codes 6 and 7 behave exactly as mode codes 2 and 3.
- R11: Elapsed ticks advance by one only on clock edges where tick_en is 1. A load or a gate restart on the same edge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter clock enable; one elapsed tick per enabled edge |
| load_stb | input | 1 | Load strobe for load_val and mode_sel |
| load_val | input | 16 | New count value (0 means 65536) |
| mode_sel | input | 3 | Operating mode captured on load |
| gate | input | 1 | Gate level; rising edges retrigger some modes |
| irq_out | output | 1 | Output waveform bit |
| count_out | output | 16 | Current readable count |

## Verification
The embedded properties assume that gate is synchronous to clk. They also assume that mode_sel and load_val matter only on cycles with load_strobe high, because the mode is taken in only at a load. The strobe and rate-pulse properties further assume that no second load or gate edge arrives on the very edge they examine; they exempt any cycle that restarts. The bench drives every input on the falling clock edge and applies loads only as separate steps. It runs each of the eight mode codes over a set of small and moderate counts, with a periodic stall pattern on tick_en and one gate rise partway through each run, so that every output is compared every cycle with an elapsed-tick model.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CNT_W  = 16;
    localparam int SPAN_W = CNT_W + 1;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } pit_mode_e;

    typedef struct packed {
        pit_mode_e           mode;
        logic [SPAN_W-1:0]   period;
    } pit_cfg_t;

    // codes 6 and 7 fold onto the rate and square modes
    function automatic pit_mode_e fold_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11)
            return pit_mode_e'({1'b0, code[1:0]});
        return pit_mode_e'(code);
    endfunction

    function automatic logic gate_retriggers(input pit_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) ||
               (m == M_SQUARE)  || (m == M_HWSTROBE);
    endfunction

    function automatic logic [SPAN_W-1:0] widen_count(input logic [CNT_W-1:0] v);
        if (v == '0)
            return SPAN_W'(1) << CNT_W;
        return {1'b0, v};
    endfunction

    function automatic logic is_oneshot_family(input pit_mode_e m);
        return (m == M_TERM) || (m == M_ONESHOT) ||
               (m == M_SWSTROBE) || (m == M_HWSTROBE);
    endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_stb,
    input  logic [CNT_W-1:0]   load_val,
    input  logic [2:0]         mode_sel,
    input  logic               gate,
    output pit_cfg_t           cfg,
    output logic [SPAN_W-1:0]  seed_period,
    output logic               restart
);

    localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(1) << CNT_W;

    logic gate_q;
    logic gate_rise;

    assign gate_rise   = gate & ~gate_q;
    assign restart     = load_stb | (gate_rise & gate_retriggers(cfg.mode));
    assign seed_period = load_stb ? widen_count(load_val) : cfg.period;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.mode   <= M_SQUARE;
            cfg.period <= FULL_SPAN;
            gate_q     <= 1'b0;
        end else begin
            gate_q <= gate;
            if (load_stb) begin
                cfg.mode   <= fold_mode(mode_sel);
                cfg.period <= widen_count(load_val);
            end
        end
    end

    p_zero_load_r1: assert property (@(posedge clk) disable iff (rst)
        (load_stb && load_val == '0) |=> (cfg.period == FULL_SPAN));

    p_alias_fold_r10: assert property (@(posedge clk) disable iff (rst)
        (load_stb && mode_sel == 3'd6) |=> (cfg.mode == M_RATE));

    p_gate_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_stb && (cfg.mode == M_TERM || cfg.mode == M_SWSTROBE)) |-> !restart);

endmodule

// File: rtl/pit_oneshot_ctr.sv
module pit_oneshot_ctr
    import pit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               tick,
    input  logic [SPAN_W-1:0]  seed_period,
    output logic [SPAN_W-1:0]  remain,
    output logic [CNT_W-1:0]   wrap_count,
    output logic               overrun
);

    // remain saturates at zero; wrap_count keeps falling modulo 2^CNT_W;
    // overrun marks that at least one tick passed beyond the terminal point
    always_ff @(posedge clk) begin
        if (rst) begin
            remain     <= SPAN_W'(1) << CNT_W;
            wrap_count <= '0;
            overrun    <= 1'b0;
        end else if (restart) begin
            remain     <= seed_period;
            wrap_count <= seed_period[CNT_W-1:0];
            overrun    <= 1'b0;
        end else if (tick) begin
            wrap_count <= wrap_count - 1'b1;
            if (remain != '0)
                remain <= remain - 1'b1;
            else
                overrun <= 1'b1;
        end
    end

    p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!restart && remain == '0) |=> (remain == '0));

    p_overrun_after_zero_r6: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (remain == '0));

    p_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(wrap_count));

endmodule

// File: rtl/pit_period_ctr.sv
module pit_period_ctr
    import pit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               tick,
    input  logic [SPAN_W-1:0]  period,
    output logic [SPAN_W-1:0]  phase,
    output logic               started
);

    logic [SPAN_W-1:0] phase_inc;

    assign phase_inc = phase + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase   <= '0;
            started <= 1'b0;
        end else if (tick) begin
            started <= 1'b1;
            phase   <= (phase_inc == period) ? '0 : phase_inc;
        end
    end

    p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
        phase < period);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         load_stb,
    input  logic [15:0]  load_val,
    input  logic [2:0]   mode_sel,
    input  logic         gate,
    output logic         irq_out,
    output logic [15:0]  count_out
);

    localparam int DBL_W = SPAN_W + 1;

    pit_cfg_t           cfg;
    logic [SPAN_W-1:0]  seed_period;
    logic               restart;
    logic [SPAN_W-1:0]  remain;
    logic [CNT_W-1:0]   wrap_count;
    logic               overrun;
    logic [SPAN_W-1:0]  phase;
    logic               started;

    logic [DBL_W-1:0]   half_period;
    logic [DBL_W-1:0]   dbl_phase;
    logic [DBL_W-1:0]   dbl_mod;
    logic [SPAN_W-1:0]  rate_left;
    logic [DBL_W-1:0]   square_left;

    pit_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .load_stb    (load_stb),
        .load_val    (load_val),
        .mode_sel    (mode_sel),
        .gate        (gate),
        .cfg         (cfg),
        .seed_period (seed_period),
        .restart     (restart)
    );

    pit_oneshot_ctr u_oneshot (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .tick        (tick_en),
        .seed_period (seed_period),
        .remain      (remain),
        .wrap_count  (wrap_count),
        .overrun     (overrun)
    );

    pit_period_ctr u_period (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick_en),
        .period  (cfg.period),
        .phase   (phase),
        .started (started)
    );

    // square wave: high for the first (N+1)/2 phases; count falls by two
    assign half_period = ({1'b0, cfg.period} + 1'b1) >> 1;
    assign dbl_phase   = {phase, 1'b0};
    assign dbl_mod     = (dbl_phase >= {1'b0, cfg.period}) ?
                         dbl_phase - {1'b0, cfg.period} : dbl_phase;
    assign square_left = {1'b0, cfg.period} - dbl_mod;
    assign rate_left   = cfg.period - phase;

    always_comb begin
        unique case (cfg.mode)
            M_TERM:     irq_out = (remain == '0);
            M_ONESHOT:  irq_out = (remain != '0);
            M_RATE:     irq_out = started && (phase == '0);
            M_SQUARE:   irq_out = ({1'b0, phase} < half_period);
            default:    irq_out = (remain == '0) && !overrun;
        endcase
    end

    always_comb begin
        if (is_oneshot_family(cfg.mode))
            count_out = wrap_count;
        else if (cfg.mode == M_RATE)
            count_out = rate_left[CNT_W-1:0];
        else
            count_out = square_left[CNT_W-1:0];
    end

    p_term_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == M_TERM && irq_out && !restart) |=> irq_out);

    p_oneshot_falls_once_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == M_ONESHOT && !irq_out && !restart) |=> !irq_out);

    p_rate_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == M_RATE && irq_out && tick_en && !restart &&
         cfg.period > SPAN_W'(1)) |=> !irq_out);

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == M_SWSTROBE || cfg.mode == M_HWSTROBE) &&
         irq_out && tick_en && !restart) |=> !irq_out);

endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        load_stb;
    logic [15:0] load_val;
    logic [2:0]  mode_sel;
    logic        gate;
    logic        irq_out;
    logic [15:0] count_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state
    int m_mode;
    int m_n;
    int m_d;
    bit m_gprev;

    always #10 clk = ~clk;

    pit_channel uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .load_stb  (load_stb),
        .load_val  (load_val),
        .mode_sel  (mode_sel),
        .gate      (gate),
        .irq_out   (irq_out),
        .count_out (count_out)
    );

    function automatic int fold(input int code);
        return (code >= 6) ? code - 4 : code;
    endfunction

    function automatic bit exp_out();
        case (m_mode)
            0: return m_d >= m_n;
            1: return m_d < m_n;
            2: return (m_d % m_n == 0) && (m_d != 0);
            3: return (m_d % m_n) < ((m_n + 1) / 2);
            default: return m_d == m_n;
        endcase
    endfunction

    function automatic int exp_cnt();
        case (m_mode)
            2: return (m_n - (m_d % m_n)) & 16'hFFFF;
            3: return (m_n - ((2 * m_d) % m_n)) & 16'hFFFF;
            default: return (m_n - m_d) & 16'hFFFF;
        endcase
    endfunction

    task automatic check_bit(input string tag, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s out: actual %0d expected %0d (mode %0d n %0d d %0d)",
                     tag, act, exp, m_mode, m_n, m_d);
        end
    endtask

    task automatic check_cnt(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s count: actual %0h expected %0h (mode %0d n %0d d %0d)",
                     tag, act, exp, m_mode, m_n, m_d);
        end
    endtask

    // one clock: drive inputs, advance model at the edge, sample at negedge
    task automatic step(input bit ld, input int val, input int md, input bit g, input bit tk);
        load_stb = ld;
        load_val = 16'(val);
        mode_sel = 3'(md);
        gate     = g;
        tick_en  = tk;
        @(posedge clk);
        if (ld) begin
            m_n    = (val == 0) ? 65536 : val;
            m_mode = fold(md);
            m_d    = 0;
        end else if (g && !m_gprev && (m_mode == 1 || m_mode == 2 ||
                                       m_mode == 3 || m_mode == 5)) begin
            m_d = 0;
        end else if (tk) begin
            m_d++;
        end
        m_gprev = g;
        @(negedge clk);
    endtask

    function automatic string out_tag(input int code, input bit after_gate);
        if (after_gate) return "R7";
        if (code >= 6)  return "R10";
        case (code)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic string cnt_tag(input int code, input bit after_gate);
        if (after_gate) return "R7";
        if (code >= 6)  return "R10";
        if (code == 2)  return "R4";
        if (code == 3)  return "R5";
        return "R8";
    endfunction

    initial begin
        int counts [8] = '{1, 2, 3, 4, 5, 7, 300, 0};
        rst = 1'b1; load_stb = 1'b0; load_val = '0; mode_sel = '0;
        gate = 1'b0; tick_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mode = 3; m_n = 65536; m_d = 0; m_gprev = 1'b0;
        // R9: reset state
        check_bit("R9", irq_out, 1'b1);
        check_cnt("R9", count_out, 0);

        // sweep every mode code over a set of counts
        for (int code = 0; code < 8; code++) begin
            foreach (counts[ci]) begin
                int len;
                int rise_at;
                len     = (counts[ci] == 0) ? 24 : 3 * counts[ci] + 6;
                rise_at = (counts[ci] == 0) ? 10 : counts[ci] + 2;
                step(1'b1, counts[ci], code, 1'b0, 1'b0);
                check_bit(out_tag(code, 1'b0), irq_out, exp_out());
                check_cnt(counts[ci] == 0 ? "R1" : cnt_tag(code, 1'b0),
                          count_out, exp_cnt());
                for (int cyc = 0; cyc < len; cyc++) begin
                    bit g;
                    bit tk;
                    bit ag;
                    g  = (cyc >= rise_at);
                    tk = (cyc % 5) != 4;   // R11: periodic stalls
                    ag = (cyc >= rise_at);
                    step(1'b0, 0, 0, g, tk);
                    check_bit(tk ? out_tag(code, ag) : "R11", irq_out, exp_out());
                    check_cnt(tk ? cnt_tag(code, ag) : "R11", count_out, exp_cnt());
                end
            end
        end

        // R1: zero load means 65536, counting down through the wrap
        step(1'b1, 0, 0, 1'b0, 1'b0);
        repeat (5) step(1'b0, 0, 0, 1'b0, 1'b1);
        check_cnt("R1", count_out, 16'hFFFB);
        check_bit("R1", irq_out, 1'b0);

        // R7: mode 0 ignores a gate rise, mode 1 restarts on it
        step(1'b1, 6, 0, 1'b0, 1'b0);
        repeat (3) step(1'b0, 0, 0, 1'b0, 1'b1);
        step(1'b0, 0, 0, 1'b1, 1'b1);
        check_cnt("R7", count_out, 2);
        step(1'b1, 6, 1, 1'b0, 1'b0);
        repeat (3) step(1'b0, 0, 0, 1'b0, 1'b1);
        step(1'b0, 0, 0, 1'b1, 1'b1);
        check_cnt("R7", count_out, 6);
        check_bit("R7", irq_out, 1'b1);

        // R11: no ticks, no movement
        step(1'b1, 4, 0, 1'b0, 1'b0);
        repeat (10) step(1'b0, 0, 0, 1'b0, 1'b0);
        check_cnt("R11", count_out, 4);

        // R8: wrap below zero in mode 4
        step(1'b1, 2, 4, 1'b0, 1'b0);
        repeat (4) step(1'b0, 0, 0, 1'b0, 1'b1);
        check_cnt("R8", count_out, 16'hFFFE);
        check_bit("R6", irq_out, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule